// File: doc/BRIEF.md
# Run-Time Selectable Maximal-Length Bit Sequence Source

This block produces a pseudo-random serial bit stream from a linear feedback shift register of the Fibonacci kind. The register length is picked at run time from five values (3, 4, 8, 16 or 32 bits). Each length has its own fixed feedback tap set that gives a maximal-length sequence, so an N-bit window repeats only after 2^N−1 shifts. It is used as a test-pattern or scrambling source. The length is chosen with a small select code and takes effect when a reseed pulse restarts the register.

Each enabled clock moves the register one place toward its top. The XOR of the tapped bits enters at the bottom. The serial output is the highest bit of the active window. A reseed pulse, or the asynchronous reset, puts the value 1 into the register. A guard stops shifting if the active window is ever all zero. A select code outside the five supported ones falls back to 32 bits and raises an error flag that stays set until reset.

Top module: `prbs_sel_top`

## Requirements
- R1: While `rst` is high, and after its release, the register holds 1 and the active length is 32. `serialOut` is therefore 0 and `badLenFlag` is 0.
- R2: Each clock with `enable` high and `reseed` low shifts the register one place toward its top, with the feedback bit entering at bit position 1. Positions are 1-based and the taps are: length 3 → 3,2; length 4 → 4,3; length 8 → 8,6,5,4; length 16 → 16,15,13,4; length 32 → 32,22,2,1.
- R3: With a nonzero start, the output stream for length N repeats every 2^N−1 clocks. One period contains exactly 2^(N−1) ones.
- R4: A clock with `reseed` high loads the value 1 into the register.
- R5: `lenSel` is sampled only on a clock with `reseed` high. The codes are 0→3, 1→4, 2→8, 3→16 and 4→32 bits. Changing `lenSel` without `reseed` does not alter the sequence.
- R6: While `enable` is low and `reseed` is low, the register and `serialOut` keep their values.
- R7: A reseed with `lenSel` equal to 5, 6 or 7 selects length 32 and sets `badLenFlag`. The flag then stays set through later reseeds until `rst`.
- R8: `rst` acts asynchronously. `serialOut` and `badLenFlag` take their reset values before any clock edge arrives.
- R9: Register bits above the active length are always zero. The active window is never all zero, and if it were, the register would hold instead of shifting.
- R10: `reseed` takes priority over `enable`, so a clock with both high loads 1 and does not shift.
- R11: `serialOut` is the register bit at position N (1-based) of the active length N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| lenSel | input | 3 | Length select code, sampled on reseed |
| enable | input | 1 | Shift enable |
| reseed | input | 1 | Load value 1 and latch the length select |
| serialOut | output | 1 | Top bit of the active window |
| badLenFlag | output | 1 | Sticky flag for an unsupported length code |

## Verification
The block has no size parameter to shrink, because its five lengths are fixed. The bench therefore uses the lengths themselves as the small configuration. For lengths 3, 4 and 8 it sweeps two full periods. For length 16 it sweeps one full period of 65535 clocks. This makes the repetition and the ones count of a maximal sequence checkable directly from the serial pin. Length 32 cannot be swept, so it is compared cycle by cycle against an arithmetic model over a few hundred steps.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

  localparam int REG_W   = 32;
  localparam int NUM_LEN = 5;
  localparam int SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    LEN3  = 3'd0,
    LEN4  = 3'd1,
    LEN8  = 3'd2,
    LEN16 = 3'd3,
    LEN32 = 3'd4
  } lenCode_e;

  typedef struct packed {
    logic     loadSeed;
    logic     shiftEn;
    lenCode_e activeLen;
  } ctrlStrobes_t;

  function automatic int lenBits(input lenCode_e c);
    case (c)
      LEN3:    return 3;
      LEN4:    return 4;
      LEN8:    return 8;
      LEN16:   return 16;
      default: return 32;
    endcase
  endfunction

  // bit p (1-based) of the tap list maps to index p-1
  function automatic logic [REG_W-1:0] tapMask(input lenCode_e c);
    logic [REG_W-1:0] m;
    m = '0;
    case (c)
      LEN3:  begin m[2] = 1'b1; m[1] = 1'b1; end
      LEN4:  begin m[3] = 1'b1; m[2] = 1'b1; end
      LEN8:  begin m[7] = 1'b1; m[5] = 1'b1; m[4] = 1'b1; m[3] = 1'b1; end
      LEN16: begin m[15] = 1'b1; m[14] = 1'b1; m[12] = 1'b1; m[3] = 1'b1; end
      default: begin m[31] = 1'b1; m[21] = 1'b1; m[1] = 1'b1; m[0] = 1'b1; end
    endcase
    return m;
  endfunction

  function automatic logic [REG_W-1:0] windowMask(input lenCode_e c);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < REG_W; i++) begin
      if (i < lenBits(c)) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic lenCode_e resolveLen(input logic [SEL_W-1:0] sel);
    if (sel <= 3'd4) return lenCode_e'(sel);
    return LEN32;
  endfunction

endpackage

// File: rtl/prbs_ctrl.sv
module prbs_ctrl
  import prbs_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [SEL_W-1:0]   lenSel,
  input  logic               enable,
  input  logic               reseed,
  output ctrlStrobes_t       strobes,
  output logic               badLenFlag
);

  localparam logic [SEL_W-1:0] MAX_GOOD = SEL_W'(NUM_LEN - 1);

  lenCode_e activeLen;
  logic     selBad;

  assign selBad = (lenSel > MAX_GOOD);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      activeLen  <= LEN32;
      badLenFlag <= 1'b0;
    end else if (reseed) begin
      activeLen <= resolveLen(lenSel);
      if (selBad) badLenFlag <= 1'b1;
    end
  end

  always_comb begin
    strobes.loadSeed  = reseed;
    strobes.shiftEn   = enable && !reseed;
    strobes.activeLen = activeLen;
  end

  assert_len_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !reseed |=> $stable(activeLen));

  assert_len_take_R5: assert property (@(posedge clk) disable iff (rst)
    (reseed && !selBad) |=> (activeLen == lenCode_e'($past(lenSel))));

  assert_bad_code_R7: assert property (@(posedge clk) disable iff (rst)
    (reseed && selBad) |=> (badLenFlag && activeLen == LEN32));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    badLenFlag |=> badLenFlag);

  assert_priority_R10: assert property (@(posedge clk) disable iff (rst)
    reseed |-> !strobes.shiftEn);

endmodule

// File: rtl/prbs_datapath.sv
module prbs_datapath
  import prbs_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  ctrlStrobes_t strobes,
  output logic         serialOut
);

  localparam logic [REG_W-1:0] SEED = REG_W'(1);

  logic [REG_W-1:0]   lfsrState;
  logic [REG_W-1:0]   winMask;
  logic [REG_W-1:0]   shifted;
  logic [NUM_LEN-1:0] fbCand;
  logic [NUM_LEN-1:0] topCand;
  logic               feedback;
  logic               lockup;

  for (genvar g = 0; g < NUM_LEN; g++) begin : gLen
    localparam lenCode_e CODE = lenCode_e'(g);
    localparam int       NB   = lenBits(CODE);
    assign fbCand[g]  = ^(lfsrState & tapMask(CODE));
    assign topCand[g] = lfsrState[NB-1];
  end

  always_comb begin
    winMask  = windowMask(strobes.activeLen);
    feedback = fbCand[strobes.activeLen];
    lockup   = ((lfsrState & winMask) == '0);
    shifted  = {lfsrState[REG_W-2:0], feedback} & winMask;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      lfsrState <= SEED;
    end else if (strobes.loadSeed) begin
      lfsrState <= SEED;
    end else if (strobes.shiftEn && !lockup) begin
      lfsrState <= shifted;
    end
  end

  assign serialOut = topCand[strobes.activeLen];

  assert_seed_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.loadSeed |=> (lfsrState == SEED));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!strobes.loadSeed && !strobes.shiftEn) |=> $stable(lfsrState));

  assert_shift_in_R2: assert property (@(posedge clk) disable iff (rst)
    (strobes.shiftEn && !lockup) |=>
      (lfsrState[0] == ^($past(lfsrState) & tapMask($past(strobes.activeLen)))));

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (lfsrState & ~windowMask(strobes.activeLen)) == '0);

  assert_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
    lfsrState != '0);

endmodule

// File: rtl/prbs_sel_top.sv
module prbs_sel_top
  import prbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] lenSel,
  input  logic             enable,
  input  logic             reseed,
  output logic             serialOut,
  output logic             badLenFlag
);

  ctrlStrobes_t strobes;

  prbs_ctrl uCtrl (
    .clk        (clk),
    .rst        (rst),
    .lenSel     (lenSel),
    .enable     (enable),
    .reseed     (reseed),
    .strobes    (strobes),
    .badLenFlag (badLenFlag)
  );

  prbs_datapath uPath (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .serialOut (serialOut)
  );

endmodule

// File: tb/tb_prbs_sel_top.sv
module tb_prbs_sel_top;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] lenSel;
  logic       enable;
  logic       reseed;
  logic       serialOut;
  logic       badLenFlag;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [31:0] mState;
  int          mLen;
  logic        hist [0:511];

  always #2 clk = ~clk;

  prbs_sel_top dut (
    .clk(clk), .rst(rst), .lenSel(lenSel), .enable(enable),
    .reseed(reseed), .serialOut(serialOut), .badLenFlag(badLenFlag)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // model of R2: 1-based tap positions, shift toward top, new bit at position 1
  function automatic logic [31:0] modelNext(input logic [31:0] s, input int n);
    logic fb;
    logic [31:0] m;
    case (n)
      3:  fb = s[2] ^ s[1];
      4:  fb = s[3] ^ s[2];
      8:  fb = s[7] ^ s[5] ^ s[4] ^ s[3];
      16: fb = s[15] ^ s[14] ^ s[12] ^ s[3];
      default: fb = s[31] ^ s[21] ^ s[1] ^ s[0];
    endcase
    m = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    return ({s[30:0], fb}) & m;
  endfunction

  function automatic logic modelOut();
    return mState[mLen-1];
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReseed(input logic [2:0] code, input int n, input logic en);
    lenSel = code;
    reseed = 1'b1;
    enable = en;
    tick();
    reseed = 1'b0;
    mState = 32'd1;
    mLen   = n;
  endtask

  // compare cycles steps against the model; returns mismatch count
  task automatic runCompare(input int steps, output int mism);
    mism = 0;
    enable = 1'b1;
    for (int k = 0; k < steps; k++) begin
      tick();
      mState = modelNext(mState, mLen);
      if (serialOut !== modelOut()) mism++;
    end
  endtask

  task automatic sweepSmall(input logic [2:0] code, input int n, input string tag);
    int p;
    int mism;
    int ones;
    int rep;
    p = (1 << n) - 1;
    doReseed(code, n, 1'b0);
    chk(serialOut == 1'b0, "R4 seed output", serialOut, 0);
    mism = 0;
    enable = 1'b1;
    hist[0] = serialOut;
    for (int k = 1; k < 2 * p; k++) begin
      tick();
      mState = modelNext(mState, mLen);
      hist[k] = serialOut;
      if (serialOut !== modelOut()) mism++;
    end
    chk(mism == 0, {tag, " R2 model match"}, mism, 0);
    ones = 0;
    rep  = 0;
    for (int k = 0; k < p; k++) begin
      if (hist[k]) ones++;
      if (hist[k] !== hist[k + p]) rep++;
    end
    chk(rep == 0, {tag, " R3 period repeat"}, rep, 0);
    chk(ones == (1 << (n - 1)), {tag, " R3 ones count"}, ones, 1 << (n - 1));
  endtask

  initial begin
    int mism;
    int ones;
    int rep;
    logic held;
    logic first16 [0:15];

    rst = 1'b1; lenSel = 3'd4; enable = 1'b0; reseed = 1'b0;
    mState = 32'd1; mLen = 32;
    repeat (3) @(negedge clk);
    chk(serialOut == 1'b0, "R1 reset output", serialOut, 0);
    chk(badLenFlag == 1'b0, "R1 reset flag", badLenFlag, 0);
    rst = 1'b0;
    tick();
    chk(serialOut == 1'b0, "R1 output after release", serialOut, 0);

    // R1/R2/R11: default length 32 from reset
    runCompare(200, mism);
    chk(mism == 0, "R1 R11 default length 32 stream", mism, 0);

    // R10: reseed with enable high loads 1, no shift (length 3)
    doReseed(3'd0, 3, 1'b1);
    chk(serialOut == 1'b0, "R10 reseed beats enable", serialOut, 0);
    tick();
    mState = modelNext(mState, mLen);
    tick();
    mState = modelNext(mState, mLen);
    chk(serialOut == 1'b1, "R10 R2 length3 second step", serialOut, 1);

    sweepSmall(3'd0, 3, "len3");
    sweepSmall(3'd1, 4, "len4");

    // R5: change select without reseed, length 4 continues
    lenSel = 3'd2;
    runCompare(30, mism);
    chk(mism == 0, "R5 select ignored without reseed", mism, 0);

    sweepSmall(3'd2, 8, "len8");

    // R6: hold with enable low
    runCompare(17, mism);
    enable = 1'b0;
    held = serialOut;
    rep = 0;
    for (int k = 0; k < 12; k++) begin
      tick();
      if (serialOut !== held) rep++;
    end
    chk(rep == 0, "R6 output held", rep, 0);
    runCompare(40, mism);
    chk(mism == 0, "R6 state held then resumes", mism, 0);

    // R3 length 16 full period
    doReseed(3'd3, 16, 1'b0);
    enable = 1'b1;
    ones = 0; mism = 0;
    for (int k = 0; k < 65535; k++) begin
      if (k < 16) first16[k] = serialOut;
      if (serialOut) ones++;
      if (serialOut !== modelOut()) mism++;
      tick();
      mState = modelNext(mState, mLen);
    end
    rep = 0;
    for (int k = 0; k < 16; k++) begin
      if (k > 0) begin
        tick();
        mState = modelNext(mState, mLen);
      end
      if (serialOut !== first16[k]) rep++;
    end
    chk(mism == 0, "len16 R2 model match", mism, 0);
    chk(ones == 32768, "len16 R3 ones count", ones, 32768);
    chk(rep == 0, "len16 R3 period repeat", rep, 0);

    // R7: unsupported code
    doReseed(3'd6, 32, 1'b0);
    chk(badLenFlag == 1'b1, "R7 flag set", badLenFlag, 1);
    runCompare(60, mism);
    chk(mism == 0, "R7 falls back to length 32", mism, 0);
    doReseed(3'd0, 3, 1'b0);
    chk(badLenFlag == 1'b1, "R7 flag sticky", badLenFlag, 1);
    runCompare(10, mism);
    chk(mism == 0, "R5 length 3 after reseed", mism, 0);
    for (int k = 0; k < 8 && serialOut == 1'b0; k++) begin
      tick();
      mState = modelNext(mState, mLen);
    end
    chk(serialOut == 1'b1, "R8 precondition output high", serialOut, 1);

    // R8: async reset between edges
    #1 rst = 1'b1;
    #0.5;
    chk(serialOut == 1'b0, "R8 async output", serialOut, 0);
    chk(badLenFlag == 1'b0, "R8 async flag", badLenFlag, 0);
    @(negedge clk);
    rst = 1'b0;
    mState = 32'd1; mLen = 32;
    runCompare(40, mism);
    chk(mism == 0, "R1 length 32 after reset", mism, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule